// File: doc/BRIEF.md
# Floating-Point Compare Condition Evaluator

This block decides a floating-point comparison predicate for two IEEE-754 operands held in 64-bit input words. A format select chooses double precision (the whole word) or single precision (the low 32 bits only). A magnitude mode clears both sign bits before the comparison. A 4-bit condition code picks which relations count toward a true result. The block also reports whether the compare raises an invalid-operation exception.

Each operand is split into sign, NaN, signalling-NaN and zero flags, plus an unsigned magnitude key. A relation stage then derives three mutually exclusive outcomes: equal, less and unordered. The condition code combines them. A single register stage holds the one-bit result and the invalid flag. Both appear with a one-cycle valid pulse on the cycle after the input strobe. A status unit downstream consumes the invalid flag. Another unit stores the result in a condition-code register.

Top module: `fp_cond_cmp`

## Requirements
- R1: If either operand is a NaN (exponent all ones, fraction nonzero), the compare is unordered, and both less and equal are false.
- R2: An unordered compare with condition bit 3 set raises `out_invalid`.
- R3: An unordered compare raises `out_invalid` whenever either operand is a signalling NaN (fraction MSB 0), regardless of condition bit 3. A quiet NaN (fraction MSB 1) with bit 3 clear does not raise it. An ordered compare never raises it.
- R4: When `abs_mode` is 1, both sign bits are treated as 0 before comparing.
- R5: Equal is true for bit-identical non-NaN operands, and +0 equals -0.
- R6: Less is true only when the operands are ordered, not equal, and A lies below B. A negative value lies below a positive one. Between two negatives, the larger magnitude is lower. Infinities order as the extreme values.
- R7: `out_cond` = (cond[2] AND less) OR (cond[1] AND equal) OR (cond[0] AND unordered).
- R8: With `fmt_dbl`=1, the operands use bit 63 as sign, bits 62:52 as exponent and bits 51:0 as fraction. With `fmt_dbl`=0, they use bit 31 as sign, bits 30:23 as exponent and bits 22:0 as fraction, and bits 63:32 are ignored.
- R9: `out_valid` is high for exactly one cycle, the cycle after each `in_valid` cycle, and carries that compare's `out_cond` and `out_invalid`. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Compare request strobe |
| op_a | input | 64 | First operand (single uses bits 31:0) |
| op_b | input | 64 | Second operand (single uses bits 31:0) |
| fmt_dbl | input | 1 | 1 = double, 0 = single |
| abs_mode | input | 1 | Compare magnitudes only |
| cond | input | 4 | Relation select (bits 2..0) and signal-on-NaN (bit 3) |
| out_valid | output | 1 | One-cycle result strobe |
| out_cond | output | 1 | Condition result |
| out_invalid | output | 1 | Invalid-operation flag |

## Verification
The bench compares +0 with -0. A design that compares raw bit patterns would report them unequal and give a false less. It also compares pairs of negative values. A design that forgets to reverse the magnitude order for negatives would return the opposite answer. The bench sends quiet and signalling NaNs with condition bit 3 set and clear, so a design that confuses the two NaN kinds, or ignores bit 3, would give a wrong invalid flag. Single-precision compares are sent with garbage in the upper word, and a double-precision compare uses a small value whose low word looks like a single NaN. A design that decodes the wrong field would misorder these cases or report them as unordered.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
  localparam int WORD_W     = 64;
  localparam int DBL_EXP_W  = 11;
  localparam int DBL_FRAC_W = 52;
  localparam int SGL_EXP_W  = 8;
  localparam int SGL_FRAC_W = 23;
  localparam int MAG_W      = DBL_EXP_W + DBL_FRAC_W;
  localparam int COND_W     = 4;

  // condition bit positions
  localparam int C_UNORD  = 0;
  localparam int C_EQUAL  = 1;
  localparam int C_LESS   = 2;
  localparam int C_SIGNAL = 3;

  typedef struct packed {
    logic             sign;
    logic             nan;
    logic             snan;
    logic             zero;
    logic [MAG_W-1:0] mag;
  } fp_class_t;
endpackage

// File: rtl/fpcmp_field.sv
module fpcmp_field
  import fpcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] bits_i,
  input  logic                  abs_mode,
  output fp_class_t             cls_o
);
  localparam int SIGN_B = EXP_W + FRAC_W;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_ones;
  logic              frac_nz;

  assign exp_f    = bits_i[SIGN_B-1:FRAC_W];
  assign frac_f   = bits_i[FRAC_W-1:0];
  assign exp_ones = &exp_f;
  assign frac_nz  = |frac_f;

  always_comb begin
    cls_o.sign = bits_i[SIGN_B] & ~abs_mode;
    cls_o.nan  = exp_ones & frac_nz;
    cls_o.snan = exp_ones & frac_nz & ~frac_f[FRAC_W-1];
    cls_o.zero = ~|bits_i[SIGN_B-1:0];
    cls_o.mag  = MAG_W'(bits_i[SIGN_B-1:0]);
  end
endmodule

// File: rtl/fpcmp_operand.sv
module fpcmp_operand
  import fpcmp_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic              fmt_dbl,
  input  logic              abs_mode,
  output fp_class_t         cls_o
);
  fp_class_t cls_fmt [2];

  for (genvar g = 0; g < 2; g++) begin : g_fmt
    localparam int EW = (g == 1) ? DBL_EXP_W  : SGL_EXP_W;
    localparam int FW = (g == 1) ? DBL_FRAC_W : SGL_FRAC_W;
    fpcmp_field #(.EXP_W(EW), .FRAC_W(FW)) u_field (
      .bits_i   (word_i[EW+FW:0]),
      .abs_mode (abs_mode),
      .cls_o    (cls_fmt[g])
    );
  end

  assign cls_o = fmt_dbl ? cls_fmt[1] : cls_fmt[0];
endmodule

// File: rtl/fpcmp_relate.sv
module fpcmp_relate
  import fpcmp_pkg::*;
(
  input  fp_class_t a_i,
  input  fp_class_t b_i,
  output logic      eq_o,
  output logic      lt_o,
  output logic      unord_o,
  output logic      snan_o
);
  logic mag_eq, mag_lt, ord_below;

  assign mag_eq = (a_i.mag == b_i.mag);
  assign mag_lt = (a_i.mag <  b_i.mag);

  always_comb begin
    unord_o = a_i.nan | b_i.nan;
    snan_o  = a_i.snan | b_i.snan;
    eq_o    = ~unord_o & ((a_i.zero & b_i.zero) |
                          ((a_i.sign == b_i.sign) & mag_eq));
    if (a_i.sign != b_i.sign)
      ord_below = a_i.sign;
    else if (a_i.sign)
      ord_below = ~mag_lt & ~mag_eq;
    else
      ord_below = mag_lt;
    lt_o = ~unord_o & ~eq_o & ord_below;
  end
endmodule

// File: rtl/fp_cond_cmp.sv
module fp_cond_cmp
  import fpcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [63:0]       op_a,
  input  logic [63:0]       op_b,
  input  logic              fmt_dbl,
  input  logic              abs_mode,
  input  logic [3:0]        cond,
  output logic              out_valid,
  output logic              out_cond,
  output logic              out_invalid
);
  fp_class_t cls_a, cls_b;
  logic eq_w, lt_w, unord_w, snan_w;
  logic res_d, inv_d;

  fpcmp_operand u_opa (.word_i(op_a), .fmt_dbl(fmt_dbl), .abs_mode(abs_mode), .cls_o(cls_a));
  fpcmp_operand u_opb (.word_i(op_b), .fmt_dbl(fmt_dbl), .abs_mode(abs_mode), .cls_o(cls_b));

  fpcmp_relate u_rel (
    .a_i(cls_a), .b_i(cls_b),
    .eq_o(eq_w), .lt_o(lt_w), .unord_o(unord_w), .snan_o(snan_w)
  );

  assign res_d = (cond[C_LESS]  & lt_w) |
                 (cond[C_EQUAL] & eq_w) |
                 (cond[C_UNORD] & unord_w);
  assign inv_d = unord_w & (cond[C_SIGNAL] | snan_w);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_cond    <= 1'b0;
      out_invalid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_cond    <= res_d;
        out_invalid <= inv_d;
      end
    end
  end

  // R9: strobe follows request by one cycle, and only then
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R2: signal-on-NaN bit
  a_r2_cond3_invalid: assert property (@(posedge clk) disable iff (rst)
    (in_valid && unord_w && cond[C_SIGNAL]) |=> out_invalid);
  // R3: ordered compares are quiet
  a_r3_ordered_quiet: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !unord_w) |=> !out_invalid);
  // R1: unordered result depends only on the unordered select
  a_r1_unord_result: assert property (@(posedge clk) disable iff (rst)
    (in_valid && unord_w) |=> (out_cond == $past(cond[C_UNORD])));
  // R5: two zeros of any sign compare equal
  a_r5_zero_equal: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cls_a.zero && cls_b.zero) |=> (out_cond == $past(cond[C_EQUAL])));
  // R6: less and equal never both hold
  a_r6_eq_lt_excl: assert property (@(posedge clk) disable iff (rst)
    !(eq_w && lt_w));
endmodule

// File: tb/fp_cond_cmp_tb.sv
module fp_cond_cmp_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic fmt_dbl = 1'b0, abs_mode = 1'b0;
  logic [3:0] cond = '0;
  logic out_valid, out_cond, out_invalid;

  int total = 0, bad = 0, cycles = 0;
  bit done = 1'b0;
  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk; // 125 MHz

  fp_cond_cmp u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .fmt_dbl(fmt_dbl), .abs_mode(abs_mode), .cond(cond),
    .out_valid(out_valid), .out_cond(out_cond), .out_invalid(out_invalid)
  );

  localparam logic [31:0] S_ONE = 32'h3F80_0000, S_TWO = 32'h4000_0000,
    S_M1 = 32'hBF80_0000, S_M2 = 32'hC000_0000, S_PZ = 32'h0, S_NZ = 32'h8000_0000,
    S_INF = 32'h7F80_0000, S_QNAN = 32'h7FC0_0000, S_SNAN = 32'h7F80_0001;
  localparam logic [63:0] D_ONE = 64'h3FF0_0000_0000_0000, D_M3 = 64'hC008_0000_0000_0000,
    D_QNAN = 64'h7FF8_0000_0000_0000, D_SNAN = 64'h7FF0_0000_0000_0001;

  task automatic chk(input string tag, input logic [63:0] a, input logic [63:0] b,
                     input logic dbl, input logic ab, input logic [3:0] c,
                     input logic e_res, input logic e_inv);
    op_a = a; op_b = b; fmt_dbl = dbl; abs_mode = ab; cond = c; in_valid = 1'b1;
    exp_q.push_back({e_res, e_inv});
    tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R9 unexpected out_valid: actual=1 expected=0");
      end else begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({out_cond, out_invalid} !== e) begin
          bad++;
          $display("FAIL %s cond/invalid: actual=%b%b expected=%b", t, out_cond, out_invalid, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d cycles expected=<20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if ({out_valid, out_cond, out_invalid} !== 3'b000) begin
      bad++;
      $display("FAIL R9 reset outputs: actual=%b expected=000", {out_valid, out_cond, out_invalid});
    end
    rst = 1'b0;
    @(negedge clk);
    // R7: relation selection bits 2(less) 1(equal) 0(unordered)
    chk("R7", {32'h0, S_ONE}, {32'h0, S_TWO}, 0, 0, 4'b0100, 1, 0);
    chk("R7", {32'h0, S_ONE}, {32'h0, S_TWO}, 0, 0, 4'b0010, 0, 0);
    chk("R7", {32'h0, S_TWO}, {32'h0, S_ONE}, 0, 0, 4'b0111, 0, 0);
    // R5: equality, signed zeros
    chk("R5", {32'h0, S_ONE}, {32'h0, S_ONE}, 0, 0, 4'b0010, 1, 0);
    chk("R5", {32'h0, S_PZ}, {32'h0, S_NZ}, 0, 0, 4'b0010, 1, 0);
    chk("R5", {32'h0, S_NZ}, {32'h0, S_PZ}, 0, 0, 4'b0100, 0, 0);
    // R6: ordering
    chk("R6", {32'h0, S_M2}, {32'h0, S_M1}, 0, 0, 4'b0100, 1, 0);
    chk("R6", {32'h0, S_M1}, {32'h0, S_M2}, 0, 0, 4'b0100, 0, 0);
    chk("R6", {32'h0, S_M1}, {32'h0, S_TWO}, 0, 0, 4'b0100, 1, 0);
    chk("R6", {32'h0, S_TWO}, {32'h0, S_INF}, 0, 0, 4'b0100, 1, 0);
    // R1: NaN unordered, less/equal false
    chk("R1", {32'h0, S_QNAN}, {32'h0, S_ONE}, 0, 0, 4'b0110, 0, 0);
    chk("R1", {32'h0, S_ONE}, {32'h0, S_QNAN}, 0, 0, 4'b0001, 1, 0);
    // R2: bit 3 signals on quiet NaN
    chk("R2", {32'h0, S_QNAN}, {32'h0, S_ONE}, 0, 0, 4'b1001, 1, 1);
    chk("R2", {32'h0, S_QNAN}, {32'h0, S_QNAN}, 0, 0, 4'b1000, 0, 1);
    // R3: signalling NaN always signals; ordered never does
    chk("R3", {32'h0, S_SNAN}, {32'h0, S_ONE}, 0, 0, 4'b0001, 1, 1);
    chk("R3", {32'h0, S_ONE}, {32'h0, S_SNAN}, 0, 0, 4'b0000, 0, 1);
    chk("R3", {32'h0, S_ONE}, {32'h0, S_TWO}, 0, 0, 4'b1111, 1, 0);
    // R4: magnitude mode
    chk("R4", {32'h0, S_M2}, {32'h0, S_ONE}, 0, 1, 4'b0100, 0, 0);
    chk("R4", {32'h0, S_M2}, {32'h0, S_ONE}, 0, 0, 4'b0100, 1, 0);
    chk("R4", {32'h0, S_M1}, {32'h0, S_ONE}, 0, 1, 4'b0010, 1, 0);
    // R8: format fields
    chk("R8", D_M3, D_ONE, 1, 0, 4'b0100, 1, 0);
    chk("R8", D_QNAN, D_ONE, 1, 0, 4'b0001, 1, 0);
    chk("R8", D_SNAN, D_ONE, 1, 0, 4'b0000, 0, 1);
    chk("R8", {32'hFFFF_FFFF, S_ONE}, {32'h0, S_ONE}, 0, 0, 4'b0010, 1, 0);
    chk("R8", {32'h0, S_QNAN}, D_ONE, 1, 0, 4'b0100, 1, 0);
    chk("R8", {32'h0, S_QNAN}, D_ONE, 1, 0, 4'b0001, 0, 0);
    // R9: idle gap, then drain
    repeat (4) @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || exp_q.size() != 0) begin
      bad++;
      $display("FAIL R9 drain: actual valid=%b pending=%0d expected valid=0 pending=0",
               out_valid, exp_q.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule